// File: doc/BRIEF.md
# Three-Channel Intercluster Message Link

This block is both ends of a point-to-point link between two processor clusters. The link has three parallel channels. A baseline channel carries a full 64-bit value and an 8-bit tag. A fast channel is narrow: it carries only a 10-bit value and the tag. A low-power channel is wide, but it is the slowest of the three. The sender accepts one message per cycle on a valid/ready stream. Each message carries a 64-bit payload, an 8-bit tag and a 2-bit class. The block picks a channel from the class and from the free space on each channel. It then moves the message through a delay pipeline that models the wire latency of that channel. At the far end, each channel presents its own valid, tag and payload.

Latency is the number of clock edges from the edge that accepts a message to the edge that ends its delivery cycle. A latency-mode pin is sampled while reset is asserted. It selects either the short point-to-point latencies or the longer per-hop latencies of a ring. Each channel can hold a parameterised number of messages in flight. When the preferred channel is full, the message falls back to the baseline channel. When the baseline channel is full too, the sender drops `in_ready`. `in_ready` depends on `in_class` and on channel occupancy, never on `in_valid`. A message transfers on an edge where `in_valid` and `in_ready` are both high. A producer that sees `in_ready` low must hold the message until it is taken. The receiver side has no back-pressure, because a wire cannot stall.

Top module: `hetero_link`

## Requirements
- R1: The class selects the preferred channel. Class 1 (operand already ready at dispatch) and class 2 (store data) prefer the low-power channel. Class 3 (value predicted narrow) prefers the fast channel, which delivers only payload bits [9:0]. Class 0 (ordinary) uses the baseline channel.
- R2: When the preferred channel of a class 1, 2 or 3 message has no free slot, the message is sent on the baseline channel with its full 64-bit payload.
- R3: `in_ready` is high exactly when the preferred channel or the baseline channel has a free slot. For class 0, only the baseline channel counts. At most one channel takes a message per cycle.
- R4: With mode 0 (point-to-point), the latencies are 2 for the baseline channel, 1 for the fast channel and 3 for the low-power channel.
- R5: With mode 1 (ring hop), the latencies are 4 for the baseline channel, 2 for the fast channel and 6 for the low-power channel.
- R6: `ring_mode` is captured only while `rst_n` is low. Changing it after reset has no effect on any latency.
- R7: A channel never holds more than its capacity of messages in flight. The defaults are 2 for baseline, 1 for fast and 2 for low-power. A slot counts as free again in the cycle its message is presented at the receiver.
- R8: Each channel delivers its messages in the order they were accepted, with tag and payload unchanged.
- R9: During reset and right after it, all three receiver valids are low and `in_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ring_mode | input | 1 | Latency set, sampled during reset: 0 point-to-point, 1 ring hop |
| in_valid | input | 1 | Sender message valid |
| in_ready | output | 1 | Sender can take the message |
| in_class | input | 2 | Message class (see R1) |
| in_tag | input | 8 | Message tag |
| in_data | input | 64 | Message payload |
| base_valid | output | 1 | Baseline channel delivery valid |
| base_tag | output | 8 | Baseline channel tag |
| base_data | output | 64 | Baseline channel payload |
| fast_valid | output | 1 | Fast channel delivery valid |
| fast_tag | output | 8 | Fast channel tag |
| fast_data | output | 10 | Fast channel narrow payload |
| lp_valid | output | 1 | Low-power channel delivery valid |
| lp_tag | output | 8 | Low-power channel tag |
| lp_data | output | 64 | Low-power channel payload |

## Verification
Random class mixes at high offered load are run in both latency modes. Mode 1 is where the capacities really bind, so that traffic separates a correct fallback from a stall and an early release of a slot from a late one. Directed bursts of store data show the low-power channel filling and the spill onto the baseline channel. Bursts of ordinary messages in ring mode force `in_ready` low. Toggling `ring_mode` after reset while checking the delivery cycles tells apart a mode captured at reset from a mode that follows the pin.

// File: rtl/hl_pkg.sv
package hl_pkg;
  localparam int DATA_W   = 64;
  localparam int TAG_W    = 8;
  localparam int NARROW_W = 10;

  typedef enum logic [1:0] {
    MC_PLAIN  = 2'd0,
    MC_RDYOP  = 2'd1,
    MC_STORE  = 2'd2,
    MC_NARROW = 2'd3
  } msg_class_e;
endpackage

// File: rtl/hl_steer.sv
module hl_steer
  import hl_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       req_valid,
  input  logic [1:0] req_class,
  input  logic       room_base,
  input  logic       room_fast,
  input  logic       room_lp,
  output logic       req_ready,
  output logic       go_base,
  output logic       go_fast,
  output logic       go_lp
);
  msg_class_e cls;
  logic want_lp, want_fast, pref_ok;

  always_comb begin
    cls       = msg_class_e'(req_class);
    want_lp   = (cls == MC_RDYOP) || (cls == MC_STORE);
    want_fast = (cls == MC_NARROW);
    pref_ok   = (want_lp && room_lp) || (want_fast && room_fast);
    req_ready = pref_ok || room_base;
    go_lp     = req_valid && want_lp && room_lp;
    go_fast   = req_valid && want_fast && room_fast;
    go_base   = req_valid && !pref_ok && room_base;
  end

  // R3
  one_route_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({go_base, go_fast, go_lp}));

  // R2
  spill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && want_lp && !room_lp && room_base) |-> go_base);
endmodule

// File: rtl/hl_lane.sv
module hl_lane #(
  parameter int DW     = 64,
  parameter int TW     = 8,
  parameter int LAT_XB = 2,
  parameter int LAT_RG = 4,
  parameter int CAP    = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ring_q,
  input  logic          push,
  input  logic [TW-1:0] push_tag,
  input  logic [DW-1:0] push_data,
  output logic          has_room,
  output logic          out_valid,
  output logic [TW-1:0] out_tag,
  output logic [DW-1:0] out_data
);
  localparam int DEPTH = (LAT_XB > LAT_RG) ? LAT_XB : LAT_RG;
  localparam int CW    = $clog2(DEPTH + 2);

  logic [DEPTH:0] vld;
  logic [TW-1:0]  tg [DEPTH+1];
  logic [DW-1:0]  dt [DEPTH+1];
  logic [CW-1:0]  occ;
  int             ins;

  always_comb begin
    ins      = ring_q ? (LAT_RG - 1) : (LAT_XB - 1);
    has_room = (int'(occ) - int'(vld[0])) < CAP;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld <= '0;
      occ <= '0;
    end else begin
      for (int i = 0; i < DEPTH; i++) begin
        if (i == ins) begin
          vld[i] <= push;
          tg[i]  <= push_tag;
          dt[i]  <= push_data;
        end else begin
          vld[i] <= vld[i+1];
          tg[i]  <= tg[i+1];
          dt[i]  <= dt[i+1];
        end
      end
      vld[DEPTH] <= 1'b0;
      tg[DEPTH]  <= '0;
      dt[DEPTH]  <= '0;
      occ <= CW'(int'(occ) + int'(push) - int'(vld[0]));
    end
  end

  assign out_valid = vld[0];
  assign out_tag   = tg[0];
  assign out_data  = dt[0];

  // R7
  occ_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    int'(occ) <= CAP);

  // R7
  occ_track_chk: assert property (@(posedge clk) disable iff (!rst_n)
    int'(occ) == $countones(vld));

  // R7
  push_room_chk: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> has_room);
endmodule

// File: rtl/hetero_link.sv
module hetero_link
  import hl_pkg::*;
#(
  parameter int CAP_BASE = 2,
  parameter int CAP_FAST = 1,
  parameter int CAP_LP   = 2,
  parameter int LB_XB = 2, parameter int LB_RG = 4,
  parameter int LF_XB = 1, parameter int LF_RG = 2,
  parameter int LL_XB = 3, parameter int LL_RG = 6
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                ring_mode,
  input  logic                in_valid,
  output logic                in_ready,
  input  logic [1:0]          in_class,
  input  logic [TAG_W-1:0]    in_tag,
  input  logic [DATA_W-1:0]   in_data,
  output logic                base_valid,
  output logic [TAG_W-1:0]    base_tag,
  output logic [DATA_W-1:0]   base_data,
  output logic                fast_valid,
  output logic [TAG_W-1:0]    fast_tag,
  output logic [NARROW_W-1:0] fast_data,
  output logic                lp_valid,
  output logic [TAG_W-1:0]    lp_tag,
  output logic [DATA_W-1:0]   lp_data
);
  logic mode_q;
  logic room_b, room_f, room_l;
  logic go_b, go_f, go_l;

  always_ff @(posedge clk) begin
    if (!rst_n) mode_q <= ring_mode;
  end

  hl_steer u_steer (
    .clk(clk), .rst_n(rst_n), .req_valid(in_valid), .req_class(in_class),
    .room_base(room_b), .room_fast(room_f), .room_lp(room_l),
    .req_ready(in_ready), .go_base(go_b), .go_fast(go_f), .go_lp(go_l)
  );

  hl_lane #(.DW(DATA_W), .TW(TAG_W), .LAT_XB(LB_XB), .LAT_RG(LB_RG), .CAP(CAP_BASE)) u_base (
    .clk(clk), .rst_n(rst_n), .ring_q(mode_q), .push(go_b), .push_tag(in_tag),
    .push_data(in_data), .has_room(room_b), .out_valid(base_valid),
    .out_tag(base_tag), .out_data(base_data)
  );

  hl_lane #(.DW(NARROW_W), .TW(TAG_W), .LAT_XB(LF_XB), .LAT_RG(LF_RG), .CAP(CAP_FAST)) u_fast (
    .clk(clk), .rst_n(rst_n), .ring_q(mode_q), .push(go_f), .push_tag(in_tag),
    .push_data(in_data[NARROW_W-1:0]), .has_room(room_f), .out_valid(fast_valid),
    .out_tag(fast_tag), .out_data(fast_data)
  );

  hl_lane #(.DW(DATA_W), .TW(TAG_W), .LAT_XB(LL_XB), .LAT_RG(LL_RG), .CAP(CAP_LP)) u_lp (
    .clk(clk), .rst_n(rst_n), .ring_q(mode_q), .push(go_l), .push_tag(in_tag),
    .push_data(in_data), .has_room(room_l), .out_valid(lp_valid),
    .out_tag(lp_tag), .out_data(lp_data)
  );

  // R6
  mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> $stable(mode_q));

  // R3
  stall_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_ready |-> !room_b);

  // R1
  narrow_fast_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_class == 2'd3 && room_f) |-> go_f);
endmodule

// File: tb/hetero_link_tb.sv
module hetero_link_tb;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0, ring_mode = 1'b0;
  logic in_valid = 1'b0, in_ready;
  logic [1:0] in_class = '0;
  logic [7:0] in_tag = '0;
  logic [63:0] in_data = '0;
  logic base_valid, fast_valid, lp_valid;
  logic [7:0] base_tag, fast_tag, lp_tag;
  logic [63:0] base_data, lp_data;
  logic [9:0] fast_data;

  always #(CLK_PERIOD/2) clk = ~clk;

  hetero_link u_dut (
    .clk(clk), .rst_n(rst_n), .ring_mode(ring_mode), .in_valid(in_valid),
    .in_ready(in_ready), .in_class(in_class), .in_tag(in_tag), .in_data(in_data),
    .base_valid(base_valid), .base_tag(base_tag), .base_data(base_data),
    .fast_valid(fast_valid), .fast_tag(fast_tag), .fast_data(fast_data),
    .lp_valid(lp_valid), .lp_tag(lp_tag), .lp_data(lp_data)
  );

  int n_chk = 0, n_bad = 0;
  int now = 0;
  bit m_ring = 0;
  bit pin_wiggle = 0;
  int          q_due [3][$];
  logic [7:0]  q_tag [3][$];
  logic [63:0] q_dat [3][$];

  function automatic int lat(int l, bit rg);
    if (l == 0) return rg ? 4 : 2;
    if (l == 1) return rg ? 2 : 1;
    return rg ? 6 : 3;
  endfunction

  function automatic int cap(int l);
    return (l == 1) ? 1 : 2;
  endfunction

  task automatic chk(bit ok, string req, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h at t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic step(bit v, logic [1:0] cls, logic [7:0] tg, logic [63:0] dat);
    bit ev [3];
    bit room [3];
    logic ov [3];
    logic [7:0] ot [3];
    logic [63:0] od [3];
    int pref, sel;
    bit er;
    string lreq;
    @(negedge clk);
    ov[0] = base_valid; ot[0] = base_tag; od[0] = base_data;
    ov[1] = fast_valid; ot[1] = fast_tag; od[1] = {54'd0, fast_data};
    ov[2] = lp_valid;   ot[2] = lp_tag;   od[2] = lp_data;
    lreq = m_ring ? (pin_wiggle ? "R5/R6" : "R5") : "R4";
    for (int l = 0; l < 3; l++) begin
      ev[l] = (q_due[l].size() > 0) && (q_due[l][0] == now);
      chk(ov[l] == ev[l], lreq, 64'(ov[l]), 64'(ev[l]));
      if (ev[l] && ov[l]) begin
        chk(ot[l] == q_tag[l][0], "R8", 64'(ot[l]), 64'(q_tag[l][0]));
        chk(od[l] == q_dat[l][0], "R8", od[l], q_dat[l][0]);
      end
      room[l] = (q_due[l].size() - (ev[l] ? 1 : 0)) < cap(l);
    end
    in_valid = v; in_class = cls; in_tag = tg; in_data = dat;
    if (pin_wiggle) ring_mode = 1'($urandom_range(0, 1));
    pref = (cls == 2'd1 || cls == 2'd2) ? 2 : (cls == 2'd3) ? 1 : 0;
    sel = room[pref] ? pref : (room[0] ? 0 : -1);
    er = (sel >= 0);
    #1;
    chk(in_ready == er, "R3/R7", 64'(in_ready), 64'(er));
    @(posedge clk);
    for (int l = 0; l < 3; l++)
      if (ev[l]) begin
        void'(q_due[l].pop_front()); void'(q_tag[l].pop_front()); void'(q_dat[l].pop_front());
      end
    if (v && er) begin
      q_due[sel].push_back(now + lat(sel, m_ring));
      q_tag[sel].push_back(tg);
      q_dat[sel].push_back(sel == 1 ? {54'd0, dat[9:0]} : dat);
    end
    now++;
  endtask

  task automatic do_reset(bit rg);
    @(negedge clk);
    rst_n = 1'b0; ring_mode = rg; in_valid = 1'b0; pin_wiggle = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R9: idle state under reset
    chk({base_valid, fast_valid, lp_valid} == 3'b000, "R9", 64'({base_valid, fast_valid, lp_valid}), 64'd0);
    chk(in_ready == 1'b1, "R9", 64'(in_ready), 64'd1);
    rst_n = 1'b1;
    m_ring = rg;
    now = 0;
    for (int l = 0; l < 3; l++) begin
      q_due[l].delete(); q_tag[l].delete(); q_dat[l].delete();
    end
  endtask

  task automatic rand_run(int n);
    for (int i = 0; i < n; i++)
      step($urandom_range(0, 3) != 0, 2'($urandom_range(0, 3)), 8'($urandom),
           {$urandom, $urandom});
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_0417));
    do_reset(1'b0);
    // R1 / R2: store burst fills the low-power channel, third spills to baseline
    step(1, 2'd2, 8'h11, 64'hA1);
    step(1, 2'd2, 8'h12, 64'hA2);
    step(1, 2'd2, 8'h13, 64'hA3);
    step(1, 2'd3, 8'h14, 64'hFFFF_0000_0000_03FF);
    step(1, 2'd1, 8'h15, 64'hB5);
    repeat (6) step(0, 2'd0, 8'h0, 64'h0);
    rand_run(300);
    do_reset(1'b1);
    // R3 / R7: ordinary burst in ring mode stalls the sender
    for (int i = 0; i < 6; i++) step(1, 2'd0, 8'(8'h20 + i), 64'(i));
    // R2: narrow burst overflows the one-slot fast channel
    for (int i = 0; i < 4; i++) step(1, 2'd3, 8'(8'h30 + i), 64'(i * 1000));
    repeat (8) step(0, 2'd0, 8'h0, 64'h0);
    rand_run(300);
    // R6: pin toggles after reset, latencies must stay at ring values
    pin_wiggle = 1;
    rand_run(300);
    pin_wiggle = 0;
    do_reset(1'b0);
    rand_run(200);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule